// File: doc/BRIEF.md
# Decade-Selectable Slow Clock Generator

This block turns a fixed 6 MHz reference clock into a slow square wave. The slow wave is meant for stepping or pacing other logic at human-visible or audio rates. A 3-bit rate setting chooses the output frequency. The choices are the six decades from 1 Hz through 100 kHz, plus a 600 kHz rate. An eighth setting switches to manual operation, where every one-cycle press pulse flips the output once. A second output drives an indicator lamp and always shows the current level of the slow clock.

Each automatic rate is produced by a counter that counts to half of the wanted period and then toggles a flip-flop, so every rate has a 50 percent duty cycle. When the setting changes, the block spends one cycle capturing the new setting. In that cycle the counter is cleared and the output keeps its level. The first half period at the new rate is therefore always full length, and the output never produces a short pulse when the rate is switched. The press pulse is assumed to be already debounced and synchronous to the reference clock.

Top module: `slowclk_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `slow_clk` and `slow_led` are both 0 after that edge, and the internal counter is cleared.
- R2: Rate codes 0, 1, 2, 3, 4, 5 and 6 select 1 Hz, 10 Hz, 100 Hz, 1 kHz, 10 kHz, 100 kHz and 600 kHz. With the 6 MHz reference, the output toggles every 3,000,000, 300,000, 30,000, 3,000, 300, 30 and 5 reference cycles respectively.
- R3: In every automatic rate the high and low phases are equal, so successive toggles are evenly spaced.
- R4: The new setting is captured on the clock edge where `rate_sel` differs from the captured setting. On that edge the output keeps its level and the counter restarts from zero. The first toggle at the new rate comes exactly one half period (as given in R2) after that capture edge.
- R5: With rate code 7 (manual) captured, each cycle in which `step_pulse` is 1 inverts `slow_clk` at the next rising edge. Without a press the output does not change.
- R6: In automatic rates `step_pulse` has no effect on the timing or level of `slow_clk`.
- R7: A press in the same cycle as a setting change is ignored, including a change into manual mode.
- R8: `slow_led` equals `slow_clk` in every cycle and in every mode.
- R9: On entering manual mode the output keeps the level it had when the setting changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 6 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 3 | Rate code: 0..6 automatic rates (1 Hz up to 600 kHz), 7 manual |
| step_pulse | input | 1 | One-cycle press pulse used in manual mode |
| slow_clk | output | 1 | Generated slow clock |
| slow_led | output | 1 | Indicator, lit while the slow clock is high |

## Verification
The properties assume that `rate_sel` and `step_pulse` are synchronous to `clk`. They also assume that the press pulse is clean, with no bounce, and that the rate setting is held through reset. The stimulus changes inputs only on falling edges. It holds `rate_sel` steady during reset and raises `step_pulse` for single cycles or short back-to-back runs. It switches rates only just after an output toggle, so no rate change can be confused with a pending toggle at the old rate.

// File: rtl/slowclk_pkg.sv
package slowclk_pkg;

    // Width of the rate code and the code that selects manual stepping.
    localparam int SEL_W = 3;
    typedef logic [SEL_W-1:0] sel_t;
    localparam sel_t SEL_MANUAL = sel_t'((1 << SEL_W) - 1);

    // Integer power of ten, used to derive decade division ratios.
    function automatic int pow10(input int k);
        int r;
        r = 1;
        for (int i = 0; i < k; i++) begin
            r = r * 10;
        end
        return r;
    endfunction

endpackage

// File: rtl/slowclk_limit.sv
// Maps a captured rate code to its half-period length in reference cycles.
module slowclk_limit #(
    parameter int REF_HZ  = 6_000_000,
    parameter int TOP_HZ  = 600_000,
    parameter int NUM_DEC = 6,
    parameter int CNT_W   = 22
) (
    input  logic [slowclk_pkg::SEL_W-1:0] sel,
    output logic [CNT_W-1:0]              half_len
);
    localparam int NUM_CODES = 1 << slowclk_pkg::SEL_W;

    logic [CNT_W-1:0] tab [NUM_CODES];

    for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
        if (i < NUM_DEC) begin : g_decade
            // decade i gives 10**i Hz
            assign tab[i] = CNT_W'(REF_HZ / (2 * slowclk_pkg::pow10(i)));
        end else if (i == NUM_DEC) begin : g_top
            assign tab[i] = CNT_W'(REF_HZ / (2 * TOP_HZ));
        end else begin : g_unused
            // manual and spare codes never run the counter
            assign tab[i] = CNT_W'(1);
        end
    end

    assign half_len = tab[sel];

endmodule

// File: rtl/slowclk_seltrack.sv
// Captures the rate code and flags the cycle in which it changes.
module slowclk_seltrack (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [slowclk_pkg::SEL_W-1:0] sel_in,
    output logic [slowclk_pkg::SEL_W-1:0] sel_q,
    output logic                          sel_chg
);
    typedef struct packed {
        logic [slowclk_pkg::SEL_W-1:0] sel;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d     = trk_q;
        trk_d.sel = sel_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign sel_q   = trk_q.sel;
    assign sel_chg = (sel_in != trk_q.sel);

endmodule

// File: rtl/slowclk_toggle.sv
// Half-period counter, output flip-flop and indicator register.
module slowclk_toggle #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_chg,
    input  logic             manual,
    input  logic [CNT_W-1:0] half_len,
    input  logic             step_pulse,
    output logic             lvl,
    output logic             ind
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lvl;
        logic             ind;
    } tog_t;

    tog_t st_d, st_q;
    logic at_end;

    assign at_end = (st_q.cnt == half_len - CNT_W'(1));

    always_comb begin
        st_d = st_q;
        if (sel_chg) begin
            // capture cycle: restart, keep level, ignore any press
            st_d.cnt = '0;
        end else if (manual) begin
            st_d.cnt = '0;
            if (step_pulse) begin
                st_d.lvl = ~st_q.lvl;
            end
        end else if (at_end) begin
            st_d.cnt = '0;
            st_d.lvl = ~st_q.lvl;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        st_d.ind = st_d.lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl = st_q.lvl;
    assign ind = st_q.ind;

endmodule

// File: rtl/slowclk_gen.sv
module slowclk_gen #(
    parameter int REF_HZ  = 6_000_000,
    parameter int TOP_HZ  = 600_000,
    parameter int NUM_DEC = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [slowclk_pkg::SEL_W-1:0] rate_sel,
    input  logic                          step_pulse,
    output logic                          slow_clk,
    output logic                          slow_led
);
    import slowclk_pkg::*;

    // The slowest rate (1 Hz) sets the counter width.
    localparam int CNT_W = $clog2(REF_HZ / 2 + 1);

    sel_t             sel_q;
    logic             sel_chg;
    logic [CNT_W-1:0] half_len;

    slowclk_seltrack u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_in  (rate_sel),
        .sel_q   (sel_q),
        .sel_chg (sel_chg)
    );

    slowclk_limit #(
        .REF_HZ  (REF_HZ),
        .TOP_HZ  (TOP_HZ),
        .NUM_DEC (NUM_DEC),
        .CNT_W   (CNT_W)
    ) u_lim (
        .sel      (sel_q),
        .half_len (half_len)
    );

    slowclk_toggle #(
        .CNT_W (CNT_W)
    ) u_tog (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_chg    (sel_chg),
        .manual     (sel_q == SEL_MANUAL),
        .half_len   (half_len),
        .step_pulse (step_pulse),
        .lvl        (slow_clk),
        .ind        (slow_led)
    );

endmodule

// File: rtl/slowclk_gen_chk.sv
module slowclk_gen_chk (
    input logic                          clk,
    input logic                          rst_n,
    input logic [slowclk_pkg::SEL_W-1:0] rate_sel,
    input logic                          step_pulse,
    input logic                          slow_clk,
    input logic                          slow_led
);
    import slowclk_pkg::*;

    // Set once a full clock edge has passed out of reset, so $past is meaningful.
    logic armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> (!slow_clk && !slow_led)); // R1

    AST_LED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (slow_led == slow_clk)); // R8

    AST_HOLD_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && rate_sel != $past(rate_sel)) |=> $stable(slow_clk)); // R4

    AST_STEP_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && rate_sel == SEL_MANUAL && $past(rate_sel) == SEL_MANUAL && step_pulse)
        |=> (slow_clk != $past(slow_clk))); // R5

    AST_MANUAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && rate_sel == SEL_MANUAL && $past(rate_sel) == SEL_MANUAL && !step_pulse)
        |=> $stable(slow_clk)); // R5

endmodule

bind slowclk_gen slowclk_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rate_sel   (rate_sel),
    .step_pulse (step_pulse),
    .slow_clk   (slow_clk),
    .slow_led   (slow_led)
);

// File: tb/slowclk_gen_bench.sv
`timescale 1ns/1ps
module slowclk_gen_bench;
    localparam int REF = 6_000_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] rate_sel = 3'd7;
    logic       step_pulse = 1'b0;
    logic       slow_clk;
    logic       slow_led;

    slowclk_gen u_slowclk_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_sel   (rate_sel),
        .step_pulse (step_pulse),
        .slow_clk   (slow_clk),
        .slow_led   (slow_led)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    int led_bad = 0;
    bit mon_en = 1'b0;
    logic prev_out = 1'b0;
    logic model_lvl = 1'b0;

    // scoreboard of expected output edges
    int    exp_cyc[$];
    logic  exp_lvl[$];
    string exp_req[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int half_of(input int hz);
        return REF / (2 * hz);
    endfunction

    task automatic push(input int c, input string req);
        model_lvl = ~model_lvl;
        exp_cyc.push_back(c);
        exp_lvl.push_back(model_lvl);
        exp_req.push_back(req);
    endtask

    // monitor: pops one expected item per observed output edge
    always @(negedge clk) begin
        if (mon_en) begin
            if (slow_led !== slow_clk) led_bad++;
            if (slow_clk !== prev_out) begin
                if (exp_cyc.size() == 0) begin
                    chk(1'b0, "R4 R6", "unexpected edge at cycle", cyc, -1);
                end else begin
                    int    c;
                    logic  l;
                    string r;
                    c = exp_cyc.pop_front();
                    l = exp_lvl.pop_front();
                    r = exp_req.pop_front();
                    chk(c == cyc, r, "edge cycle", cyc, c);
                    chk(slow_clk === l, r, "edge level", int'(slow_clk), int'(l));
                end
            end
            prev_out = slow_clk;
        end
    end

    task automatic pending_empty(input string req);
        #1;
        chk(exp_cyc.size() == 0, req, "missing edges", exp_cyc.size(), 0);
    endtask

    // Automatic phase: select code, expect n toggles every L cycles after capture.
    task automatic auto_phase(input logic [2:0] code, input int L, input int n,
                              input int press_off, input string req);
        int cap;
        int stop;
        @(negedge clk);
        rate_sel = code;
        cap = cyc + 1;
        for (int k = 1; k <= n; k++) push(cap + L * k, req);
        stop = (n > 0) ? cap + L * n + 1 : cap + 2000;
        if (press_off > 0) begin
            repeat (press_off) @(negedge clk);
            step_pulse = 1'b1;        // R6: press must not disturb the rate
            @(negedge clk);
            step_pulse = 1'b0;
        end
        while (cyc < stop) @(negedge clk);
        pending_empty(req);
    endtask

    task automatic enter_manual(input bit press_same);
        @(negedge clk);
        rate_sel   = 3'd7;
        step_pulse = press_same;      // R7: press in capture cycle is ignored
        @(negedge clk);
        step_pulse = 1'b0;
        repeat (10) @(negedge clk);
        #1;
        chk(slow_clk === model_lvl, "R9", "level kept in manual", int'(slow_clk), int'(model_lvl));
        chk(exp_cyc.size() == 0, "R7", "edges after ignored press", exp_cyc.size(), 0);
    endtask

    task automatic man_burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            step_pulse = 1'b1;
            push(cyc + 1, "R5");
        end
        @(negedge clk);
        step_pulse = 1'b0;
        repeat (8) @(negedge clk);
        pending_empty("R5");
    endtask

    task automatic run_all();
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(slow_clk === 1'b0, "R1", "slow_clk in reset", int'(slow_clk), 0);
        chk(slow_led === 1'b0, "R1", "slow_led in reset", int'(slow_led), 0);
        prev_out = slow_clk;
        mon_en = 1'b1;
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        pending_empty("R1");

        auto_phase(3'd6, half_of(600_000), 6, 7, "R2 R3 R6");
        auto_phase(3'd5, half_of(100_000), 4, 12, "R2 R3 R6");
        auto_phase(3'd4, half_of(10_000), 3, 0, "R2 R3 R4");
        auto_phase(3'd3, half_of(1_000), 3, 0, "R2 R3 R4");
        auto_phase(3'd2, half_of(100), 1, 0, "R2 R4");
        auto_phase(3'd1, half_of(10), 0, 0, "R2");
        auto_phase(3'd0, half_of(1), 0, 0, "R2");
        auto_phase(3'd6, half_of(600_000), 2, 0, "R4");

        enter_manual(1'b1);
        man_burst(1);
        man_burst(1);
        man_burst(3);
        enter_manual(1'b0);

        auto_phase(3'd6, half_of(600_000), 2, 0, "R4 R9");
        chk(led_bad == 0, "R8", "indicator mismatch cycles", led_bad, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190_000) @(posedge clk);
                chk(1'b0, "R2", "watchdog expired at cycle", cyc, 190_000);
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule